// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of a synchronous DRAM burst. A one-cycle start pulse loads a start column and captures the burst settings: a length code and an ordering bit. From the next cycle on, the block presents one column per clock on `col_o`, qualified by `valid_o`. The flag `last_o` marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of that size. The ordering bit selects either a wrapping count or an XOR pattern over the low address bits. Full-page bursts walk through every column of the page, wrap at the page end and keep running until a stop pulse arrives. A new start pulse may arrive at any time. It abandons the running burst and begins a new one at any column. Command decoding, data transfer and the array lie outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: While and after reset, with no start pulse, `valid_o` and `last_o` are low.
- R2: A start pulse in cycle t makes beat 0 appear in cycle t+1, with `valid_o` high and `col_o` equal to the `col_i` sampled in cycle t. A start pulse during a running burst discards that burst and restarts at the new column.
- R3: Length codes on `len_code_i` are 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8 and 3'b111 = full page. The reserved codes 3'b100 to 3'b110 behave as 1 beat.
- R4: With `ilv_i` = 0 (sequential) and length BL in {2,4,8}, beat n carries the start's upper bits unchanged. Its low log2(BL) bits equal (start low bits + n) mod BL.
- R5: With `ilv_i` = 1 (interleaved) and length BL in {2,4,8}, beat n carries the start's upper bits unchanged. Its low log2(BL) bits equal start low bits XOR n.
- R6: Length 1 outputs only the start column for one beat, whatever the ordering bit.
- R7: Full page outputs (start + n) mod 2^COL_W on beat n and ignores the ordering bit. It continues past the page end until stopped, and never raises `last_o`.
- R8: `last_o` is high only on beat BL-1 of a fixed-length burst. Without a new start, `valid_o` is low in the following cycle.
- R9: A stop pulse in a cycle where `valid_o` is high and no start is present makes `valid_o` low in the next cycle. A stop while idle has no effect. Start has priority over stop.
- R10: `col_i`, `len_code_i` and `ilv_i` are sampled only in the start cycle. Changing them during a burst does not alter its addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle burst start |
| col_i | input | COL_W | Start column, sampled with start |
| len_code_i | input | 3 | Burst length code, sampled with start |
| ilv_i | input | 1 | 0 = sequential, 1 = interleaved, sampled with start |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach is the full-page wrap: a burst must run for more than a whole page of beats before the column rolls over from 511 to 0. The bench starts a full-page burst near the top of the page. It then starts a second one at column 0 with the ordering bit set and lets that one run for 520 beats before stopping it. The bench also covers a restart mid-burst, a start and stop in the same cycle, and mode inputs that change during a burst. A behavioural reference model is compared against the outputs on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef struct packed {
    logic       full;     // full-page burst
    logic [1:0] len_log;  // log2 of fixed length
  } burst_mode_t;

  function automatic burst_mode_t decode_len(input logic [2:0] code);
    burst_mode_t m;
    m.full = 1'b0;
    unique case (code)
      3'b001:  m.len_log = 2'd1;
      3'b010:  m.len_log = 2'd2;
      3'b011:  m.len_log = 2'd3;
      3'b111:  begin m.len_log = 2'd0; m.full = 1'b1; end
      default: m.len_log = 2'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/burst_mode_latch.sv
module burst_mode_latch
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] base_o,
  output burst_mode_t      mode_o,
  output logic             ilv_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      mode_o <= '0;
      ilv_o  <= 1'b0;
    end else if (load_i) begin
      base_o <= col_i;
      mode_o <= decode_len(len_code_i);
      ilv_o  <= ilv_i;
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             final_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      beat_o   <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      beat_o   <= '0;
    end else if (active_o) begin
      if (stop_i || final_i) active_o <= 1'b0;
      else                   beat_o   <= beat_o + 1'b1;
    end
  end

  // R2
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && beat_o == '0));
  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && stop_i && !start_i) |=> !active_o);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_mode_t      mode_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] base, input logic [COL_W-1:0] n,
    input burst_mode_t m, input logic ilv);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] low;
    mask = ~({COL_W{1'b1}} << m.len_log);
    low  = ilv ? (base ^ n) : (base + n);
    if (m.full) return base + n;
    return (base & ~mask) | (low & mask);
  endfunction

  assign col_o = beat_col(base_i, beat_i, mode_i, ilv_i);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] base;
  burst_mode_t      mode;
  logic             ilv;
  logic             active;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] final_idx;
  logic             final_beat;

  burst_mode_latch #(.COL_W(COL_W)) mode_i0 (
    .clk(clk), .rst_n(rst_n), .load_i(start_i), .col_i(col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i),
    .base_o(base), .mode_o(mode), .ilv_o(ilv));

  assign final_idx  = ~({COL_W{1'b1}} << mode.len_log);
  assign final_beat = active && !mode.full && (beat == final_idx);

  burst_beat_ctr #(.COL_W(COL_W)) ctr_i0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .final_i(final_beat), .active_o(active), .beat_o(beat));

  burst_col_gen #(.COL_W(COL_W)) gen_i0 (
    .base_i(base), .beat_i(beat), .mode_i(mode), .ilv_i(ilv),
    .col_o(col_o));

  assign valid_o = active;
  assign last_o  = final_beat;

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(col_i)));
  // R7
  no_last_fullpage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode.full) |-> !last_o);
  // R8
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);
  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  // R4
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !stop_i && !start_i && !mode.full) |=>
      ((col_o >> mode.len_log) == ($past(col_o) >> mode.len_log)));
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, ilv_i = 1'b0, stop_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o));

  int tests = 0, fails = 0, cycles = 0;
  string tag = "R1";

  // behavioural reference
  int m_act = 0, m_n = 0, m_base = 0, m_len = 1, m_ilv = 0;

  function automatic int len_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int lo;
    if (m_len == 0) return (m_base + m_n) % PAGE;
    lo = m_base % m_len;
    if (m_ilv != 0) return (m_base - lo) + (lo ^ m_n);
    return (m_base - lo) + ((lo + m_n) % m_len);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act = 1; m_n = 0; m_base = int'(col_i);
      m_len = len_of(int'(len_code_i)); m_ilv = int'(ilv_i);
    end else if (m_act != 0) begin
      if (stop_i || (m_len != 0 && m_n == m_len - 1)) m_act = 0;
      else m_n++;
    end
  end

  always @(negedge clk) begin
    int e_last;
    e_last = (m_act != 0 && m_len != 0 && m_n == m_len - 1) ? 1 : 0;
    tests++;
    if (int'(valid_o) != m_act || int'(last_o) != e_last ||
        (m_act != 0 && int'(col_o) != exp_col())) begin
      fails++;
      $display("FAIL %s: valid=%0d last=%0d col=%0d expected valid=%0d last=%0d col=%0d",
               tag, valid_o, last_o, col_o, m_act, e_last,
               (m_act != 0) ? exp_col() : 0);
    end
  end

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // start a burst, then stop after stop_at beats (-1: never), run total cycles
  task automatic burst(input string t, input int c, input int code,
                       input bit il, input int total, input int stop_at,
                       input bit junk);
    tag = t;
    @(negedge clk);
    start_i = 1'b1; col_i = COL_W'(c); len_code_i = 3'(code); ilv_i = il;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      stop_i  = (i == stop_at);
      if (junk) begin
        col_i = COL_W'(c + 37 * i + 11); len_code_i = 3'(i + 5); ilv_i = ~ilv_i;
      end
    end
    stop_i = 1'b0;
  endtask

  initial begin
    tag = "R1";
    idle(3);
    tests++;
    if (valid_o !== 1'b0 || last_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: valid=%0d last=%0d expected 0 0", valid_o, last_o);
    end
    rst_n = 1'b1;
    idle(3);
    burst("R2", 5, 3, 0, 10, -1, 0);
    burst("R4", 6, 1, 0, 4, -1, 0);
    burst("R4", 13, 2, 0, 6, -1, 0);
    burst("R4", 510, 3, 0, 10, -1, 0);
    burst("R5", 3, 1, 1, 4, -1, 0);
    burst("R5", 6, 2, 1, 6, -1, 0);
    burst("R5", 205, 3, 1, 10, -1, 0);
    burst("R6", 77, 0, 1, 3, -1, 0);
    burst("R3", 99, 5, 0, 3, -1, 0);
    burst("R3", 42, 6, 1, 3, -1, 0);
    burst("R8", 16, 3, 0, 9, -1, 0);
    burst("R9", 40, 3, 0, 6, 2, 0);
    tag = "R9"; stop_i = 1'b1; idle(3); stop_i = 1'b0;
    burst("R10", 200, 3, 1, 10, -1, 1);
    burst("R7", 500, 7, 0, 30, 25, 0);
    burst("R7", 0, 7, 1, 530, 520, 0);
    // R2 restart mid-burst
    burst("R2", 120, 3, 0, 3, -1, 0);
    burst("R2", 300, 2, 1, 6, -1, 0);
    // R9 start and stop together: start wins
    tag = "R9";
    @(negedge clk); start_i = 1'b1; col_i = 9'd60; len_code_i = 3'd2; ilv_i = 1'b0;
    @(negedge clk); start_i = 1'b1; stop_i = 1'b1; col_i = 9'd90;
    @(negedge clk); start_i = 1'b0; stop_i = 1'b0;
    idle(6);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; tests++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule